// File: doc/BRIEF.md
# Mode-Selectable Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load strobe captures a full starting address. The upper bits are held for the whole burst. The two lowest bits then step through the four offsets of their aligned group, moving one beat each time the advance strobe is high.

A static order-select input chooses the stepping order:
- Linear order adds the beat number to the start offset and wraps inside the group.
- Interleaved order combines the start offset with the beat number by bitwise XOR.

With the advance strobe low, the address stays where it is. The burst is only suspended, and it resumes from that beat when advance returns. Advancing past the fourth beat wraps back to the first beat's offset.

The output address comes straight from state registers through a small offset map. A load or advance sampled at a clock edge therefore shows on the address right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset (rst_n low) is applied, and on the first clock after it is released, addr is all zeros.
- R2: A clock edge with ld high makes addr equal to the ld_addr value sampled at that edge, starting immediately after that edge.
- R3: With order_sel high (interleaved), after k advances since the last load, addr[1:0] equals start XOR (k mod 4). For example, start 01 gives 01, 00, 11, 10.
- R4: With order_sel low (linear), after k advances since the last load, addr[1:0] equals (start + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R5: A clock edge with both ld and adv low leaves addr unchanged.
- R6: After the fourth beat, one more advance returns addr[1:0] to the start offset of the burst. The same holds in both orders.
- R7: When ld and adv are both high at the same edge, the load wins: addr becomes ld_addr and the beat count restarts at zero.
- R8: addr bits above bit 1 change only at an edge with ld high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Start a new burst from ld_addr |
| ld_addr | input | ADDR_W (20) | Starting address of the burst |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = interleaved (XOR) order, 0 = linear wrapping order |
| addr | output | ADDR_W (20) | Current beat address |

## Verification
Load and advance can both arrive at the same clock edge. The load must win, and the beat count must restart rather than land one beat ahead.

The bench provokes this in two ways:
- a directed step raises both strobes in the middle of a burst;
- the random phase draws ld and adv independently, so the two strobes coincide often.

Each such cycle is judged against a bench model in which the load discards the advance. That model requires addr to equal the new load address exactly, and the next advance must then yield the second beat of the new start offset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Which beat orderings an instance supports
   typedef enum logic [1:0] {
      ORD_BOTH        = 2'd0,
      ORD_LINEAR_ONLY = 2'd1,
      ORD_XOR_ONLY    = 2'd2
   } order_support_e;

   // Level of the order-select input that chooses interleaved order
   localparam logic SEL_INTERLEAVED = 1'b1;

endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
   parameter int OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             adv,
   output logic [OFS_W-1:0] beat
);

   localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

   initial begin
      assert (OFS_W >= 1) else $error("OFS_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         beat <= '0;
      else if (ld)
         beat <= '0;
      else if (adv)
         beat <= beat + ONE;
   end

endmodule

// File: rtl/burst_start_latch.sv
module burst_start_latch #(
   parameter int ADDR_W = 20,
   parameter int OFS_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld,
   input  logic [ADDR_W-1:0]       ld_addr,
   output logic [OFS_W-1:0]        start_ofs,
   output logic [ADDR_W-OFS_W-1:0] upper
);

   initial begin
      assert (ADDR_W > OFS_W) else $error("ADDR_W must exceed OFS_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_ofs <= '0;
         upper     <= '0;
      end else if (ld) begin
         start_ofs <= ld_addr[OFS_W-1:0];
         upper     <= ld_addr[ADDR_W-1:OFS_W];
      end
   end

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
   import burst_seq_pkg::*;
#(
   parameter int             OFS_W   = 2,
   parameter order_support_e SUPPORT = ORD_BOTH
) (
   input  logic [OFS_W-1:0] start_ofs,
   input  logic [OFS_W-1:0] beat,
   input  logic             order_sel,
   output logic [OFS_W-1:0] ofs
);

   logic [OFS_W-1:0] xor_ofs;
   logic [OFS_W-1:0] lin_ofs;

   // Interleaved order: combine start and beat bit by bit
   for (genvar i = 0; i < OFS_W; i++) begin : g_xor_bit
      assign xor_ofs[i] = start_ofs[i] ^ beat[i];
   end

   // Linear order: the adder truncates, which gives the wrap inside the group
   assign lin_ofs = start_ofs + beat;

   if (SUPPORT == ORD_LINEAR_ONLY) begin : g_lin
      assign ofs = lin_ofs;
   end else if (SUPPORT == ORD_XOR_ONLY) begin : g_xor
      assign ofs = xor_ofs;
   end else begin : g_both
      assign ofs = (order_sel == SEL_INTERLEAVED) ? xor_ofs : lin_ofs;
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int             ADDR_W  = 20,
   parameter int             OFS_W   = 2,
   parameter order_support_e SUPPORT = ORD_BOTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              adv,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] addr
);

   localparam int UP_W = ADDR_W - OFS_W;

   initial begin
      assert (UP_W >= 1) else $error("no upper address bits left");
   end

   logic [OFS_W-1:0] start_ofs;
   logic [OFS_W-1:0] beat;
   logic [OFS_W-1:0] ofs;
   logic [UP_W-1:0]  upper;

   burst_start_latch #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ld),
      .ld_addr   (ld_addr),
      .start_ofs (start_ofs),
      .upper     (upper)
   );

   burst_beat_counter #(.OFS_W(OFS_W)) u_beat (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld),
      .adv   (adv),
      .beat  (beat)
   );

   burst_offset_map #(.OFS_W(OFS_W), .SUPPORT(SUPPORT)) u_map (
      .start_ofs (start_ofs),
      .beat      (beat),
      .order_sel (order_sel),
      .ofs       (ofs)
   );

   assign addr = {upper, ofs};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 20,
   parameter int OFS_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld,
   input logic [ADDR_W-1:0] ld_addr,
   input logic              adv,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr,
   input logic [OFS_W-1:0]  beat
);

   localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

   logic [OFS_W-1:0] low;
   logic [OFS_W-1:0] low_plus;
   logic [OFS_W-1:0] beat_step;

   assign low       = addr[OFS_W-1:0];
   assign low_plus  = low + ONE;
   assign beat_step = beat ^ (beat + ONE);

   // R2, R7: a load takes effect on the next cycle, whatever adv is
   a_r2_load_takes_address: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> addr == $past(ld_addr));

   // R5: no strobe means no movement (unless the order was switched)
   a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv) |=> ($stable(addr) || !$stable(order_sel)));

   // R8: upper bits move only on a load
   a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> addr[ADDR_W-1:OFS_W] == $past(addr[ADDR_W-1:OFS_W]));

   // R4: a linear step adds one to the offset
   a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv && !order_sel) |=> (order_sel || low == $past(low_plus)));

   // R3: an interleaved step flips the bits in which the beat count changes
   a_r3_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv && order_sel) |=> (!order_sel || low == ($past(low) ^ $past(beat_step))));

   // R7: a load restarts the beat count
   a_r7_load_restarts_beat: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> beat == '0);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld        (ld),
   .ld_addr   (ld_addr),
   .adv       (adv),
   .order_sel (order_sel),
   .addr      (addr),
   .beat      (beat)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic          adv = 1'b0;
   logic          order_sel = 1'b1;
   logic [AW-1:0] addr;

   int n_vec = 0;
   int n_bad = 0;

   // Bench model of the burst state
   logic [1:0]    m_start = 2'b00;
   logic [1:0]    m_k = 2'b00;
   logic [AW-3:0] m_up = '0;

   burst_addr_seq i_burst_addr_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ld),
      .ld_addr   (ld_addr),
      .adv       (adv),
      .order_sel (order_sel),
      .addr      (addr)
   );

   always #10 clk = ~clk;

   function automatic logic [AW-1:0] expect_addr(input logic [AW-3:0] up, input logic [1:0] s,
                                                 input logic [1:0] k, input logic mode);
      logic [1:0] o;
      o = mode ? (s ^ k) : (s + k);
      return {up, o};
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: addr=%h expected %h", tag, act, exp);
      end
   endtask

   // Drive one cycle at a falling edge, update the model, check at the next falling edge
   task automatic step(input logic l, input logic [AW-1:0] a, input logic v, input logic m);
      string         tag;
      logic [AW-3:0] up_before;
      up_before = m_up;
      ld = l; ld_addr = a; adv = v; order_sel = m;
      if (l) begin
         m_start = a[1:0];
         m_up    = a[AW-1:2];
         m_k     = 2'b00;
         tag     = v ? "R7" : "R2";
      end else if (v) begin
         m_k = m_k + 2'd1;
         if (m_k == 2'b00) tag = "R6";
         else if (m) tag = "R3";
         else tag = "R4";
      end else begin
         tag = "R5";
      end
      @(negedge clk);
      check(tag, addr, expect_addr(m_up, m_start, m_k, m));
      if (!l) check("R8", {addr[AW-1:2], 2'b00}, {up_before, 2'b00});
   endtask

   initial begin
      #4000000;
      n_bad++;
      $display("FAIL watchdog: timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1", addr, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", addr, '0);

      // Interleaved from 01, then wrap
      step(1'b1, 20'hABCD1, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b1);
      // Suspend mid burst
      step(1'b0, '0, 1'b1, 1'b1);
      step(1'b0, 20'hFFFFF, 1'b0, 1'b1);
      step(1'b0, '0, 1'b1, 1'b1);

      // Linear from 10: 10, 11, 00, 01, then back to 10
      step(1'b1, 20'h12342, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b0);

      // Load and advance together in the middle of a burst
      step(1'b0, '0, 1'b1, 1'b0);
      step(1'b1, 20'h55553, 1'b1, 1'b0);
      step(1'b0, '0, 1'b1, 1'b0);

      // Random phase; order changes only with a load
      for (int i = 0; i < 2000; i++) begin
         logic l, v, m;
         l = ($urandom_range(0, 5) == 0);
         v = ($urandom_range(0, 2) != 0);
         m = l ? logic'($urandom_range(0, 1)) : order_sel;
         step(l, AW'($urandom), v, m);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule